// File: doc/BRIEF.md
# Monitor Channel Message Transmitter

This block sends a message of one to eight bytes over a frame-slotted monitor channel. In each frame it drives one slot byte and an active-low enable line (`e_n`). It reads back the active-low acknowledge line (`a_n`) from the far end. A single-cycle `frame_stb` marks the end of every frame. On that edge the block samples `a_n` for the frame just ending and sets `e_n` and `slot_byte` for the next frame. Conversion to a serial bit stream happens outside this block; that stage sends the byte most significant bit first, and an idle slot is all ones.

A client places the bytes in `msg_data`, with byte i at bits `[8*i+7:8*i]`, and the count in `msg_len`. It then pulses `send_req`. The block copies the message into its own store, so it can send the message again from the start whenever the receiver aborts or a byte gets no answer in time. Completion and each abort appear as one-cycle pulses.

Top module: `mon_msg_tx`

## Requirements
- R1: While reset is asserted and right after it, `e_n` is 1, `slot_byte` is 8'hFF, and `busy`, `done` and `aborted` are 0.
- R2: `e_n` and `slot_byte` change only on the clock edge where `frame_stb` is high.
- R3: A transmission starts only after `a_n` has been sampled 1 at two consecutive frame ends. The first frame of the transmission has `e_n` = 0 and carries byte 0.
- R4: Each byte stays on the line for at least two frames. Pre-acknowledge of byte 0 is `a_n` = 0, and pre-acknowledge of any later byte is `a_n` = 1. A pre-acknowledge level seen in a byte's first frame is ignored.
- R5: After the pre-acknowledge of a byte that is not the last, exactly one frame follows with `e_n` = 1 carrying the next byte. The frames after it carry that same byte with `e_n` = 0.
- R6: After the pre-acknowledge of the last byte, `e_n` stays 1 and `slot_byte` is 8'hFF. If `a_n` = 0 at the end of that frame, `done` pulses and the block returns to idle.
- R7: If `a_n` is 1 at the end of the frame that follows a pre-acknowledge, this is an abort. `aborted` pulses and the whole message restarts from byte 0 under the rule of R3.
- R8: A byte held for 16 frames without a valid pre-acknowledge causes `aborted` and a restart from byte 0. `e_n` is never low for more than 16 consecutive frames.
- R9: `send_req` is accepted only when idle and with `msg_len` from 1 to 8. Any other request has no effect, and the stored message does not change while busy.
- R10: When not busy, `e_n` is 1 and `slot_byte` is 8'hFF. `busy` is high from acceptance until `done`.
- R11: `done` and `aborted` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle frame-end strobe |
| a_n | input | 1 | Acknowledge from receiver, active low |
| send_req | input | 1 | Request to send the presented message |
| msg_len | input | LEN_W (4) | Number of bytes, 1 to MAX_BYTES |
| msg_data | input | MAX_BYTES*8 (64) | Message bytes, byte i at [8*i+7:8*i] |
| e_n | output | 1 | Enable bit for the current frame, active low |
| slot_byte | output | 8 | Byte for the current frame's slot |
| busy | output | 1 | Message in progress |
| done | output | 1 | Pulse: message acknowledged |
| aborted | output | 1 | Pulse: abort or timeout, restart begins |

## Verification
The hardest state to reach is the retransmission path. It needs a pre-acknowledge followed one frame later by a missing acknowledge, both on byte 0 and on a later byte, where the pre-acknowledge levels have opposite polarity. The bench scripts the receiver's acknowledge level frame by frame from a table, so each abort lands in the exact frame after a pre-acknowledge. It then confirms that the next transmitted byte is byte 0 again. The timeout is reached by holding the acknowledge line inactive for 16 frames of one byte. During that window a competing request arrives and must not disturb the stored message.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SEND  = 2'd2,
        ST_CHECK = 2'd3
    } tx_state_e;
endpackage

// File: rtl/mon_tx_line_watch.sv
module mon_tx_line_watch #(
    parameter int FREE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic a_n,
    output logic line_free
);
    localparam int CW = $clog2(FREE_FRAMES + 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (frame_stb) begin
            if (!a_n)
                run_d = '0;
            else if (run_q != CW'(FREE_FRAMES))
                run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // counts the frame now ending when the line is idle in it
    assign line_free = a_n && (run_q >= CW'(FREE_FRAMES - 1));
endmodule

// File: rtl/mon_tx_msg_store.sv
module mon_tx_msg_store
    import mon_tx_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [MAX_BYTES*BYTE_W-1:0] msg_data,
    input  logic [LEN_W-1:0]            msg_len,
    input  logic [LEN_W-1:0]            rd_idx,
    output logic [BYTE_W-1:0]           rd_byte,
    output logic [LEN_W-1:0]            len_q
);
    logic [BYTE_W-1:0] bank_q [MAX_BYTES];
    logic [LEN_W-1:0]  len_d;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bank
        logic [BYTE_W-1:0] slot_d;
        always_comb slot_d = load ? msg_data[g*BYTE_W +: BYTE_W] : bank_q[g];
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[g] <= '0;
            else        bank_q[g] <= slot_d;
        end
    end

    always_comb len_d = load ? msg_len : len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    always_comb begin
        rd_byte = IDLE_BYTE;
        for (int i = 0; i < MAX_BYTES; i++)
            if (rd_idx == LEN_W'(i)) rd_byte = bank_q[i];
    end
endmodule

// File: rtl/mon_msg_tx.sv
module mon_msg_tx
    import mon_tx_pkg::*;
#(
    parameter int MAX_BYTES      = 8,
    parameter int TIMEOUT_FRAMES = 16,
    parameter int FREE_FRAMES    = 2,
    parameter int LEN_W          = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_stb,
    input  logic                        a_n,
    input  logic                        send_req,
    input  logic [LEN_W-1:0]            msg_len,
    input  logic [MAX_BYTES*BYTE_W-1:0] msg_data,
    output logic                        e_n,
    output logic [BYTE_W-1:0]           slot_byte,
    output logic                        busy,
    output logic                        done,
    output logic                        aborted
);
    localparam int REP_W = $clog2(TIMEOUT_FRAMES + 1);

    typedef struct packed {
        tx_state_e        state;
        logic [LEN_W-1:0] idx;
        logic [REP_W-1:0] rep;
        logic             done;
        logic             aborted;
    } tx_reg_t;

    tx_reg_t          r_d, r_q;
    logic             accept;
    logic             line_free;
    logic             preack;
    logic             at_end;
    logic [REP_W-1:0] rep_next;
    logic [BYTE_W-1:0] cur_byte;
    logic [LEN_W-1:0] len_q;

    mon_tx_line_watch #(.FREE_FRAMES(FREE_FRAMES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .a_n       (a_n),
        .line_free (line_free)
    );

    mon_tx_msg_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .msg_data (msg_data),
        .msg_len  (msg_len),
        .rd_idx   (r_q.idx),
        .rd_byte  (cur_byte),
        .len_q    (len_q)
    );

    always_comb begin
        accept   = send_req && (r_q.state == ST_IDLE) &&
                   (msg_len != '0) && (msg_len <= LEN_W'(MAX_BYTES));
        // byte 0 is pre-acknowledged by A going active, later bytes by A dropping
        preack   = (r_q.idx == '0) ? !a_n : a_n;
        at_end   = (r_q.idx == len_q);
        rep_next = r_q.rep + 1'b1;

        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.aborted = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) r_d.state = ST_ARM;
            end
            ST_ARM: begin
                if (frame_stb && line_free) begin
                    r_d.state = ST_SEND;
                    r_d.idx   = '0;
                    r_d.rep   = '0;
                end
            end
            ST_SEND: begin
                if (frame_stb) begin
                    if (preack && rep_next >= REP_W'(2)) begin
                        r_d.state = ST_CHECK;
                        r_d.idx   = r_q.idx + 1'b1;
                    end else if (rep_next >= REP_W'(TIMEOUT_FRAMES)) begin
                        r_d.state   = ST_ARM;
                        r_d.aborted = 1'b1;
                    end else begin
                        r_d.rep = rep_next;
                    end
                end
            end
            ST_CHECK: begin
                if (frame_stb) begin
                    if (a_n) begin
                        r_d.state   = ST_ARM;
                        r_d.aborted = 1'b1;
                    end else if (at_end) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_SEND;
                        r_d.rep   = REP_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.idx     <= '0;
            r_q.rep     <= '0;
            r_q.done    <= 1'b0;
            r_q.aborted <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign e_n       = (r_q.state != ST_SEND);
    assign slot_byte = ((r_q.state == ST_SEND) || (r_q.state == ST_CHECK && !at_end))
                       ? cur_byte : IDLE_BYTE;
    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign aborted   = r_q.aborted;
endmodule

// File: rtl/mon_msg_tx_chk.sv
module mon_msg_tx_chk #(
    parameter int MAX_BYTES      = 8,
    parameter int TIMEOUT_FRAMES = 16,
    parameter int LEN_W          = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic             a_n,
    input logic             send_req,
    input logic [LEN_W-1:0] msg_len,
    input logic             e_n,
    input logic [7:0]       slot_byte,
    input logic             busy,
    input logic             done,
    input logic             aborted
);
    localparam int LW = $clog2(TIMEOUT_FRAMES + 2) + 1;

    logic [1:0]    free_cnt, hi_cnt;
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt <= '0;
            hi_cnt   <= '0;
            lo_cnt   <= '0;
        end else if (frame_stb) begin
            free_cnt <= !a_n ? 2'd0 : (free_cnt == 2'd2 ? 2'd2 : free_cnt + 2'd1);
            hi_cnt   <= e_n ? (hi_cnt == 2'd2 ? 2'd2 : hi_cnt + 2'd1) : 2'd0;
            lo_cnt   <= e_n ? '0 : lo_cnt + 1'b1;
        end
    end

    a_r2_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_stb) |-> ($stable(e_n) && $stable(slot_byte)));

    a_r3_start_after_free: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(e_n) && hi_cnt == 2'd2) |-> (free_cnt == 2'd2));

    a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= LW'(TIMEOUT_FRAMES));

    a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(send_req) && $past(msg_len) != '0 &&
                         $past(msg_len) <= LEN_W'(MAX_BYTES)));

    a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (e_n && slot_byte == 8'hFF));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && aborted));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |=> !aborted);
endmodule

bind mon_msg_tx mon_msg_tx_chk #(
    .MAX_BYTES      (MAX_BYTES),
    .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
    .LEN_W          (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .a_n       (a_n),
    .send_req  (send_req),
    .msg_len   (msg_len),
    .e_n       (e_n),
    .slot_byte (slot_byte),
    .busy      (busy),
    .done      (done),
    .aborted   (aborted)
);

// File: tb/mon_msg_tx_tb.sv
module mon_msg_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        a_n = 1'b1;
    logic        send_req = 1'b0;
    logic [3:0]  msg_len = 4'd3;
    logic [63:0] msg_data = 64'h0000_0000_0033_2211;
    logic        e_n, busy, done, aborted;
    logic [7:0]  slot_byte;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int abort_cnt = 0;
    bit finished = 1'b0;
    logic       post_e;
    logic [7:0] post_b;
    int r2_bad = 0;

    always #2 clk = ~clk;

    mon_msg_tx u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .a_n(a_n),
        .send_req(send_req), .msg_len(msg_len), .msg_data(msg_data),
        .e_n(e_n), .slot_byte(slot_byte), .busy(busy), .done(done), .aborted(aborted)
    );

    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (aborted) abort_cnt <= abort_cnt + 1;
    end

    // {req, a_n, exp e_n, exp slot_byte}
    localparam logic [10:0] VEC [30] = '{
        {1'b1,1'b1,1'b1,8'hFF}, {1'b0,1'b1,1'b1,8'hFF}, {1'b0,1'b1,1'b0,8'h11},
        {1'b0,1'b0,1'b0,8'h11}, {1'b0,1'b0,1'b1,8'h22}, {1'b0,1'b0,1'b0,8'h22},
        {1'b0,1'b1,1'b0,8'h22}, {1'b0,1'b0,1'b1,8'h33}, {1'b0,1'b0,1'b0,8'h33},
        {1'b0,1'b1,1'b0,8'h33}, {1'b0,1'b0,1'b1,8'hFF},
        {1'b1,1'b1,1'b1,8'hFF}, {1'b0,1'b1,1'b1,8'hFF}, {1'b0,1'b1,1'b0,8'h11},
        {1'b0,1'b0,1'b0,8'h11}, {1'b0,1'b1,1'b1,8'h22}, {1'b0,1'b1,1'b1,8'hFF},
        {1'b0,1'b1,1'b0,8'h11}, {1'b0,1'b0,1'b0,8'h11}, {1'b0,1'b0,1'b1,8'h22},
        {1'b0,1'b1,1'b0,8'h22}, {1'b0,1'b1,1'b1,8'h33}, {1'b0,1'b1,1'b1,8'hFF},
        {1'b0,1'b1,1'b0,8'h11}, {1'b0,1'b0,1'b0,8'h11}, {1'b0,1'b0,1'b1,8'h22},
        {1'b0,1'b1,1'b0,8'h22}, {1'b0,1'b0,1'b1,8'h33}, {1'b0,1'b1,1'b0,8'h33},
        {1'b0,1'b0,1'b1,8'hFF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); send_req = 1'b1;
        @(negedge clk); send_req = 1'b0;
    endtask

    // one frame: drive A, sample this frame's outputs, strobe the frame end
    task automatic run_frame(input logic a, output logic e, output logic [7:0] b);
        @(negedge clk);
        a_n = a; e = e_n; b = slot_byte;
        if (e !== post_e || b !== post_b) r2_bad++;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        post_e = e_n; post_b = slot_byte;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic e;
        logic [7:0] b;
        int lows;
        repeat (3) @(negedge clk);
        // R1: reset levels
        check(e_n && slot_byte == 8'hFF && !busy && !done && !aborted, "R1 reset state",
              {e_n, slot_byte, busy}, {1'b1, 8'hFF, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        post_e = e_n; post_b = slot_byte;

        // table: normal send, byte-0 abort, later-byte abort, resend (R3..R7)
        for (int i = 0; i < 30; i++) begin
            if (VEC[i][10]) pulse_req();
            run_frame(VEC[i][9], e, b);
            check(e == VEC[i][8] && b == VEC[i][7:0], "R3/R4/R5/R6/R7 frame",
                  {e, b}, VEC[i][8:0]);
            if (i == 5) check(busy == 1'b1, "R10 busy during message", busy, 1);
        end
        @(negedge clk);
        check(done_cnt == 2, "R6 done pulses", done_cnt, 2);
        check(abort_cnt == 2, "R7 abort pulses", abort_cnt, 2);
        check(!busy, "R10 idle after done", busy, 0);

        // R8 timeout, with an ignored request while busy (R9)
        pulse_req();
        run_frame(1'b1, e, b);
        run_frame(1'b1, e, b);
        lows = 0;
        for (int k = 0; k < 16; k++) begin
            if (k == 3) begin
                msg_data = 64'h0000_0000_0000_5544; msg_len = 4'd2;
                pulse_req();
            end
            run_frame(1'b1, e, b);
            if (!e && b == 8'h11) lows++;
        end
        check(lows == 16, "R8 byte held 16 frames", lows, 16);
        run_frame(1'b1, e, b);
        check(e && b == 8'hFF, "R8 release after timeout", {e, b}, 9'h1FF);
        check(abort_cnt == 3, "R8 timeout abort pulse", abort_cnt, 3);
        run_frame(1'b1, e, b);
        check(!e && b == 8'h11, "R9 stored message kept, restart byte 0", {e, b}, 9'h011);

        // R1 reset mid-message
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(e_n && slot_byte == 8'hFF && !busy, "R1 reset while busy",
              {e_n, slot_byte, busy}, {1'b1, 8'hFF, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        post_e = e_n; post_b = slot_byte;

        // R9 invalid lengths ignored
        msg_data = 64'h0000_0000_0000_00AA;
        msg_len = 4'd0; pulse_req();
        repeat (2) @(negedge clk);
        check(!busy, "R9 length 0 ignored", busy, 0);
        msg_len = 4'd9; pulse_req();
        repeat (2) @(negedge clk);
        check(!busy, "R9 length 9 ignored", busy, 0);

        // single-byte message, early pre-ack level ignored (R4, R6)
        msg_len = 4'd1; pulse_req();
        run_frame(1'b1, e, b);
        run_frame(1'b1, e, b);
        run_frame(1'b0, e, b);
        check(!e && b == 8'hAA, "R4 first frame pre-ack ignored", {e, b}, 9'h0AA);
        run_frame(1'b0, e, b);
        check(!e && b == 8'hAA, "R4 byte repeated", {e, b}, 9'h0AA);
        run_frame(1'b0, e, b);
        check(e && b == 8'hFF, "R6 end of message level", {e, b}, 9'h1FF);
        @(negedge clk);
        check(done_cnt == 3 && !busy, "R6 single byte done", done_cnt, 3);
        check(abort_cnt == 3, "R11 no stray abort", abort_cnt, 3);
        check(r2_bad == 0, "R2 outputs stable within frames", r2_bad, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule